// File: doc/BRIEF.md
# Serial-fed memory programming sequencer

This block sits between a byte-wide serial receiver/transmitter pair and a non-volatile memory array. After reset it loads its write pointer and its pulse length from two configuration inputs, announces readiness by sending the ready character 0xFF to the host, and then takes an open-ended stream of data bytes. Each byte goes to the next consecutive location. The block captures address and data with a latch enable, applies a program enable for a set number of timebase ticks, drops the enables in the reverse order, reads the location back and returns the value read to the host as verification data. There is no end-of-stream command: the session lasts until the next reset.

The controller is a single state machine with the states ST_INIT, ST_HELLO, ST_IDLE, ST_LATCH, ST_PULSE, ST_RELEASE, ST_READ and ST_ECHO. ST_INIT loads the configuration and moves on unconditionally to ST_HELLO. ST_HELLO offers 0xFF and moves to ST_IDLE when the transmit port accepts it. ST_IDLE holds receive ready high and moves to ST_LATCH when a byte arrives. ST_LATCH moves unconditionally to ST_PULSE. ST_PULSE stays until the tick count is reached, then moves to ST_RELEASE. ST_RELEASE, ST_READ move unconditionally to ST_READ and ST_ECHO in turn. ST_ECHO offers the readback byte and returns to ST_IDLE, stepping the pointer, when it is accepted. The pulse timer and the address pointer are small submodules under the top.

Top module: `burn_seq`

## Requirements
- R1: While reset is asserted and in the cycle after, mem_latch, mem_pgm, rx_ready and tx_valid are 0; the first byte offered on the transmit port after each reset is 0xFF, and rx_ready stays 0 until that byte is accepted.
- R2: The first byte of a session is programmed at the address on cfg_start_addr when reset was released (typically tied to 0xD000).
- R3: Each later byte goes to the previous address plus one, the 16-bit pointer wrapping from 0xFFFF to 0x0000 with no other effect.
- R4: For each byte mem_latch rises in a cycle with mem_pgm low, mem_pgm is high only while mem_latch is high, mem_latch stays high for at least one cycle after mem_pgm falls, and mem_addr and mem_wdata are steady while mem_latch is high; mem_wdata is the received byte.
- R5: mem_pgm stays high for exactly cfg_pulse_len cycles in which tick is 1 (the last of them ends the pulse); a length of 0 acts as 1.
- R6: After each pulse, with both enables low, the block reads mem_rdata at the programmed address and sends exactly that value on tx_data, one echo per received byte, in order.
- R7: rx_ready is 0 from the cycle a byte is accepted until the echo for it has been accepted; while tx_valid is high and tx_ready is low, tx_valid and tx_data hold.
- R8: Changes of cfg_start_addr or cfg_pulse_len during a session have no effect on addresses or pulse lengths until the next reset.
- R9: The session never ends by itself; bytes keep being accepted and programmed until reset, and a new reset starts a new session with a fresh ready character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase tick for the program pulse |
| cfg_start_addr | input | 16 | First address, sampled after reset |
| cfg_pulse_len | input | 16 | Pulse length in ticks, sampled after reset |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte present |
| rx_ready | output | 1 | Block accepts a received byte |
| tx_data | output | 8 | Byte to send to host |
| tx_valid | output | 1 | Byte to send present |
| tx_ready | input | 1 | Transmitter accepts the byte |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_latch | output | 1 | Latch enable for address and data |
| mem_pgm | output | 1 | Program pulse enable |
| mem_rdata | input | 8 | Memory read data, combinational from mem_addr |

## Verification
The bench builds the block with its default widths of a 16-bit pointer, 8-bit data and a 16-bit pulse counter, so the wrap from 0xFFFF to 0x0000 is reached simply by starting a session at 0xFFFE. Short pulse lengths of 0, 1, 2 and 3 ticks with a tick every third cycle keep each byte to a few dozen cycles while still exercising a tick landing on the first and last pulse cycle. A bench memory model that can only clear bits makes the readback differ from the written byte when a location is programmed twice, which the third session does across the wrap.

// File: rtl/burn_pkg.sv
package burn_pkg;
    typedef enum logic [2:0] {
        ST_INIT,
        ST_HELLO,
        ST_IDLE,
        ST_LATCH,
        ST_PULSE,
        ST_RELEASE,
        ST_READ,
        ST_ECHO
    } burn_state_t;
endpackage

// File: rtl/burn_addr_ptr.sv
module burn_addr_ptr #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    output logic [AW-1:0] ptr
);
    localparam logic [AW-1:0] ONE = AW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= load_val;
        end else if (step) begin
            ptr <= ptr + ONE;
        end
    end

    // R3: a step from the top address lands on zero
    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && ptr == {AW{1'b1}}) |=> (ptr == '0));
endmodule

// File: rtl/burn_pulse_timer.sv
module burn_pulse_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] len_in,
    input  logic          clear,
    input  logic          run,
    input  logic          tick,
    output logic          done
);
    logic [CW-1:0] target_q;
    logic [CW-1:0] cnt_q;
    logic [CW:0]   cnt_nxt;

    assign cnt_nxt = {1'b0, cnt_q} + {{CW{1'b0}}, tick};
    assign done    = run && (cnt_nxt >= {1'b0, target_q});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            target_q <= CW'(1);
        end else if (load) begin
            target_q <= (len_in == '0) ? CW'(1) : len_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (run && tick) begin
            cnt_q <= cnt_nxt[CW-1:0];
        end
    end

    // R5: the count never runs past the target while the pulse is active
    p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < target_q));
endmodule

// File: rtl/burn_seq.sv
module burn_seq
    import burn_pkg::*;
#(
    parameter int          AW         = 16,
    parameter int          DW         = 8,
    parameter int          CW         = 16,
    parameter logic [7:0]  READY_CHAR = 8'hFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [AW-1:0] cfg_start_addr,
    input  logic [CW-1:0] cfg_pulse_len,
    input  logic [DW-1:0] rx_data,
    input  logic          rx_valid,
    output logic          rx_ready,
    output logic [DW-1:0] tx_data,
    output logic          tx_valid,
    input  logic          tx_ready,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_latch,
    output logic          mem_pgm,
    input  logic [DW-1:0] mem_rdata
);
    localparam logic [DW-1:0] HELLO = DW'(READY_CHAR);

    burn_state_t   state_q, state_d;
    logic [DW-1:0] data_q;
    logic [DW-1:0] echo_q;
    logic [AW-1:0] ptr;
    logic          pulse_done;
    logic          cfg_load;
    logic          ptr_step;
    logic          timer_clear;
    logic          timer_run;

    assign cfg_load    = (state_q == ST_INIT);
    assign ptr_step    = (state_q == ST_ECHO) && tx_ready;
    assign timer_clear = (state_q == ST_LATCH);
    assign timer_run   = (state_q == ST_PULSE);

    burn_addr_ptr #(.AW(AW)) addr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cfg_load),
        .load_val (cfg_start_addr),
        .step     (ptr_step),
        .ptr      (ptr)
    );

    burn_pulse_timer #(.CW(CW)) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (cfg_load),
        .len_in (cfg_pulse_len),
        .clear  (timer_clear),
        .run    (timer_run),
        .tick   (tick),
        .done   (pulse_done)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_INIT;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INIT:    state_d = ST_HELLO;
            ST_HELLO:   if (tx_ready) state_d = ST_IDLE;
            ST_IDLE:    if (rx_valid) state_d = ST_LATCH;
            ST_LATCH:   state_d = ST_PULSE;
            ST_PULSE:   if (pulse_done) state_d = ST_RELEASE;
            ST_RELEASE: state_d = ST_READ;
            ST_READ:    state_d = ST_ECHO;
            ST_ECHO:    if (tx_ready) state_d = ST_IDLE;
            default:    state_d = ST_INIT;
        endcase
    end

    // data capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            echo_q <= '0;
        end else begin
            if (state_q == ST_IDLE && rx_valid) data_q <= rx_data;
            if (state_q == ST_READ)             echo_q <= mem_rdata;
        end
    end

    // outputs
    always_comb begin
        rx_ready  = 1'b0;
        tx_valid  = 1'b0;
        tx_data   = echo_q;
        mem_latch = 1'b0;
        mem_pgm   = 1'b0;
        mem_addr  = ptr;
        mem_wdata = data_q;
        unique case (state_q)
            ST_INIT:    ;
            ST_HELLO:   begin tx_valid = 1'b1; tx_data = HELLO; end
            ST_IDLE:    rx_ready = 1'b1;
            ST_LATCH:   mem_latch = 1'b1;
            ST_PULSE:   begin mem_latch = 1'b1; mem_pgm = 1'b1; end
            ST_RELEASE: mem_latch = 1'b1;
            ST_READ:    ;
            ST_ECHO:    tx_valid = 1'b1;
            default:    ;
        endcase
    end

    // R4: the program pulse only occurs under the latch
    p_pgm_in_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_pgm |-> mem_latch);
    // R4: the latch opens before the pulse starts
    p_latch_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_latch) |-> !mem_pgm);
    // R4: the latch outlasts the pulse
    p_latch_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_pgm) |-> mem_latch);
    // R4: address and data hold under the latch
    p_latch_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_latch && $past(mem_latch)) |-> ($stable(mem_addr) && $stable(mem_wdata)));
    // R7: transmit data holds under backpressure
    p_tx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
    // R7: no new byte is taken while a byte is being sent
    p_rx_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |-> !tx_valid && !mem_latch);
endmodule

// File: tb/burn_seq_tb_top.sv
module burn_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [15:0] cfg_start_addr = 16'hD000;
    logic [15:0] cfg_pulse_len = 16'd2;
    logic [7:0]  rx_data = '0;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_latch;
    logic        mem_pgm;
    logic [7:0]  mem_rdata;

    burn_seq dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cfg_start_addr(cfg_start_addr), .cfg_pulse_len(cfg_pulse_len),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_latch(mem_latch), .mem_pgm(mem_pgm), .mem_rdata(mem_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int errors = 0;
    int checks = 0;

    // memory model: erased 0xFF, programming can only clear bits
    logic [7:0] dev_mem [int];
    logic [7:0] ref_mem [int];
    assign mem_rdata = dev_mem.exists(int'(mem_addr)) ? dev_mem[int'(mem_addr)] : 8'hFF;

    // scoreboard queues
    logic [7:0]  exp_tx [$];
    logic [15:0] exp_addr [$];
    logic [7:0]  exp_wd [$];
    int          exp_ticks = 2;
    logic [15:0] exp_ptr;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // stimulus: tick every third cycle, tx_ready backpressure pattern
    int cyc = 0;
    initial begin
        forever begin
            @(posedge clk); #1;
            cyc++;
            tick     = (cyc % 3 == 0);
            tx_ready = (cyc % 5 != 1) && (cyc % 7 != 2);
        end
    end

    // monitor
    bit         pgm_prev = 0;
    int         tick_cnt = 0;
    bit         hello_seen = 0;
    bit         pending = 0;
    bit         hold_prev = 0;
    logic [7:0] hold_data = '0;
    bit         latch_prev = 0;
    bit         pgm_seen_in_latch = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            pgm_prev = 0; tick_cnt = 0; hello_seen = 0; pending = 0;
            hold_prev = 0; latch_prev = 0;
        end else begin
            if (mem_latch && mem_pgm)
                dev_mem[int'(mem_addr)] = mem_mmask(int'(mem_addr)) & mem_wdata;
            if (mem_pgm && !pgm_prev) begin
                tick_cnt = 0;
                if (exp_addr.size() == 0) begin
                    check(0, "R9 unexpected write", int'(mem_addr), 0);
                end else begin
                    logic [15:0] ea;
                    logic [7:0]  ew;
                    ea = exp_addr.pop_front();
                    ew = exp_wd.pop_front();
                    check(mem_addr == ea, "R2/R3 write address", int'(mem_addr), int'(ea));
                    check(mem_wdata == ew, "R4 write data", int'(mem_wdata), int'(ew));
                end
            end
            if (mem_pgm && tick) tick_cnt++;
            if (!mem_pgm && pgm_prev)
                check(tick_cnt == exp_ticks, "R5 pulse ticks", tick_cnt, exp_ticks);
            if (!mem_latch && latch_prev)
                check(!pgm_prev, "R4 latch drop after pulse", int'(pgm_prev), 0);
            if (rx_ready && (!hello_seen || pending))
                check(0, "R1/R7 rx_ready early", 1, 0);
            if (hold_prev)
                check(tx_valid && tx_data == hold_data, "R7 tx hold", int'(tx_data), int'(hold_data));
            hold_prev = tx_valid && !tx_ready;
            hold_data = tx_data;
            if (rx_valid && rx_ready) pending = 1;
            if (tx_valid && tx_ready) begin
                if (exp_tx.size() == 0) begin
                    check(0, "R6 unexpected tx", int'(tx_data), 0);
                end else begin
                    logic [7:0] et;
                    et = exp_tx.pop_front();
                    check(tx_data == et, hello_seen ? "R6 echo value" : "R1 ready char",
                          int'(tx_data), int'(et));
                end
                if (hello_seen) pending = 0;
                hello_seen = 1;
            end
            pgm_prev   = mem_pgm;
            latch_prev = mem_latch;
        end
    end

    function automatic logic [7:0] mem_mmask(input int a);
        return dev_mem.exists(a) ? dev_mem[a] : 8'hFF;
    endfunction

    // driver
    task automatic send_byte(input logic [7:0] b);
        logic [7:0] old;
        old = ref_mem.exists(int'(exp_ptr)) ? ref_mem[int'(exp_ptr)] : 8'hFF;
        ref_mem[int'(exp_ptr)] = old & b;
        exp_addr.push_back(exp_ptr);
        exp_wd.push_back(b);
        exp_tx.push_back(old & b);
        exp_ptr = exp_ptr + 16'd1;
        while (!rx_ready) begin @(posedge clk); #1; end
        rx_valid = 1'b1;
        rx_data  = b;
        @(posedge clk); #1;
        rx_valid = 1'b0;
    endtask

    task automatic start_session(input logic [15:0] sa, input logic [15:0] len);
        rst_n = 1'b0;
        cfg_start_addr = sa;
        cfg_pulse_len  = len;
        exp_ticks = (len == 0) ? 1 : int'(len);
        exp_ptr   = sa;
        exp_tx.push_back(8'hFF);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!mem_latch && !mem_pgm && !rx_ready && !tx_valid, "R1 reset outputs",
              int'({mem_latch, mem_pgm, rx_ready, tx_valid}), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        check(!mem_latch && !mem_pgm && !rx_ready && !tx_valid, "R1 first cycle after reset",
              int'({mem_latch, mem_pgm, rx_ready, tx_valid}), 0);
        @(posedge clk); #1;
    endtask

    task automatic drain();
        int n = 0;
        while ((exp_tx.size() != 0 || exp_addr.size() != 0) && n < 2000) begin
            @(posedge clk); #1; n++;
        end
        check(exp_tx.size() == 0 && exp_addr.size() == 0, "R6 all echoes returned",
              exp_tx.size(), 0);
        repeat (4) @(posedge clk); #1;
    endtask

    initial begin
        // session 1: default start, two-tick pulses
        start_session(16'hD000, 16'd2);
        send_byte(8'h5A);
        send_byte(8'h00);
        send_byte(8'hA5);
        send_byte(8'hFF);
        send_byte(8'h3C);
        drain();
        // session 2: wrap, config changed mid-session (R8)
        start_session(16'hFFFE, 16'd3);
        send_byte(8'h12);
        cfg_start_addr = 16'h1234;
        cfg_pulse_len  = 16'd1;
        send_byte(8'h34);
        send_byte(8'h56);
        send_byte(8'h78);
        drain();
        // session 3: zero length acts as one, reprogram across wrap (R9)
        start_session(16'hFFFF, 16'd0);
        send_byte(8'h0F);
        send_byte(8'hF0);
        send_byte(8'hC3);
        drain();
        // session 4: single-tick pulses at a low address
        start_session(16'h0010, 16'd1);
        for (int i = 0; i < 6; i++) send_byte(8'(i * 37 + 1));
        drain();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired R9 actual=%0d expected=%0d", WATCHDOG, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule